// File: doc/BRIEF.md
# Two-Region Buffer Ownership Controller

This controller sits on the hardware side of a shared memory that is split into two halves. At any moment software may change one half and the custom hardware may change the other. Ownership is decided by a single toggle handshake. Software flips a request bit through a small register port. When the hardware has finished with its half, it pulses `hw_done`. The controller then hands both halves over and copies the request value into the acknowledge bit. Software detects completion by seeing acknowledge equal to request. That moment is the synchronization point.

The controller does not hold the memory array. It drives two region-select outputs and passes on, or refuses, each side's write enable before the enable reaches a dual-region RAM. The `phase` bit is always equal to acknowledge. Software owns region `phase` and hardware owns region `~phase`. Any write aimed at a region the writer does not own is dropped, and a sticky violation flag is set.

The sequencer has three states. `ST_IDLE` means request equals acknowledge. `ST_WAIT` means a swap is pending. `ST_HANDOVER` is a one-cycle transfer during which neither side owns anything. The transitions are:
- IDLE→WAIT when request differs from acknowledge and `hw_done` is low.
- IDLE→HANDOVER when request differs from acknowledge and `hw_done` is high.
- WAIT→IDLE on withdrawal, when request again equals acknowledge.
- WAIT→HANDOVER when `hw_done` is high.
- HANDOVER→IDLE always.

Top module: `dbuf_own_ctrl`

## Requirements
- R1: After reset, request, acknowledge, phase and violation are all 0, `sw_region` is 0 and `hw_region` is 1.
- R2: Register reads are combinational. Address 0 returns request in bit 0. Address 1 returns acknowledge in bit 0. Address 2 returns status: bit 0 is violation, bit 1 is phase, bit 2 is pending. Every other bit, and address 3, read 0.
- R3: A write to address 0 loads bit 0 of the write data into request at that clock edge. Writes to addresses 1 to 3 change nothing.
- R4: Pending reads 1 whenever request differs from acknowledge. Acknowledge keeps its value until a hand-over happens.
- R5: If `hw_done` is high at a rising edge where request differs from acknowledge and no hand-over is in progress, a hand-over cycle starts. Acknowledge and phase then toggle at the next rising edge.
- R6: `hw_done` at an edge where request equals acknowledge has no effect.
- R7: `sw_region` always equals phase, and `hw_region` always equals its inverse.
- R8: `sw_mem_we_ok` is high only when `sw_mem_we` is high, `sw_mem_sel` equals phase, and no hand-over is in progress.
- R9: `hw_mem_we_ok` is high only when `hw_mem_we` is high, `hw_mem_sel` differs from phase, and no hand-over is in progress.
- R10: A refused write from either side sets the violation bit at the next edge. The bit stays set until reset.
- R11: A request write during the hand-over cycle is ignored.
- R12: If software writes request back to the acknowledge value before `hw_done` arrives, the swap is withdrawn, and a later `hw_done` leaves acknowledge unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| hw_done | input | 1 | Hardware finished with its region (pulse) |
| sw_mem_we | input | 1 | Software memory write enable |
| sw_mem_sel | input | 1 | Region targeted by the software write |
| hw_mem_we | input | 1 | Hardware memory write enable |
| hw_mem_sel | input | 1 | Region targeted by the hardware write |
| sw_region | output | 1 | Region currently owned by software |
| hw_region | output | 1 | Region currently owned by hardware |
| sw_mem_we_ok | output | 1 | Software write enable passed to the RAM |
| hw_mem_we_ok | output | 1 | Hardware write enable passed to the RAM |

## Verification
On every cycle, the assertions check:
- the write gating of both sides against the current phase and the hand-over;
- the stickiness of the violation bit;
- that acknowledge stays put when nothing is pending;
- that a request write cannot land during a hand-over;
- that `hw_done` on a pending swap leads to a hand-over and then a toggle.

Only the bench scenarios can show the register map contents and that a request write reaches acknowledge with the right latency. The same holds for a withdrawn swap ignoring a later `hw_done`, and for reset clearing the violation bit.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT     = 2'd1,
        ST_HANDOVER = 2'd2
    } own_state_e;

    localparam int ADR_REQ  = 0;
    localparam int ADR_ACK  = 1;
    localparam int ADR_STAT = 2;

    localparam int STAT_VIOL  = 0;
    localparam int STAT_PHASE = 1;
    localparam int STAT_PEND  = 2;

endpackage

// File: rtl/dbuf_hs_fsm.sv
module dbuf_hs_fsm
    import dbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr_en,
    input  logic req_wr_val,
    input  logic hw_done,
    output logic req_q,
    output logic ack_q,
    output logic handover
);

    own_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_q != ack_q)
                    state_d = hw_done ? ST_HANDOVER : ST_WAIT;
            end
            ST_WAIT: begin
                if (req_q == ack_q)  state_d = ST_IDLE;
                else if (hw_done)    state_d = ST_HANDOVER;
            end
            ST_HANDOVER: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        handover = (state_q == ST_HANDOVER);
    end

    // handshake bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            ack_q <= 1'b0;
        end else begin
            if (req_wr_en && state_q != ST_HANDOVER)
                req_q <= req_wr_val;
            if (state_q == ST_HANDOVER)
                ack_q <= ~ack_q;
        end
    end

endmodule

// File: rtl/dbuf_wr_gate.sv
module dbuf_wr_gate (
    input  logic mem_we,
    input  logic mem_sel,
    input  logic owned_region,
    input  logic freeze,
    output logic we_ok,
    output logic refused
);

    logic allowed;

    always_comb begin
        allowed = (mem_sel == owned_region) && !freeze;
        we_ok   = mem_we && allowed;
        refused = mem_we && !allowed;
    end

endmodule

// File: rtl/dbuf_reg_port.sv
module dbuf_reg_port
    import dbuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              req_q,
    input  logic              ack_q,
    input  logic              refuse_any,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              req_wr_en,
    output logic              req_wr_val,
    output logic              viol_q
);

    always_comb begin
        req_wr_en  = reg_we && (reg_addr == ADDR_W'(ADR_REQ));
        req_wr_val = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          viol_q <= 1'b0;
        else if (refuse_any) viol_q <= 1'b1;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADR_REQ)) begin
            reg_rdata[0] = req_q;
        end else if (reg_addr == ADDR_W'(ADR_ACK)) begin
            reg_rdata[0] = ack_q;
        end else if (reg_addr == ADDR_W'(ADR_STAT)) begin
            reg_rdata[STAT_VIOL]  = viol_q;
            reg_rdata[STAT_PHASE] = ack_q;
            reg_rdata[STAT_PEND]  = req_q ^ ack_q;
        end
    end

endmodule

// File: rtl/dbuf_own_ctrl.sv
module dbuf_own_ctrl
    import dbuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hw_done,
    input  logic              sw_mem_we,
    input  logic              sw_mem_sel,
    input  logic              hw_mem_we,
    input  logic              hw_mem_sel,
    output logic              sw_region,
    output logic              hw_region,
    output logic              sw_mem_we_ok,
    output logic              hw_mem_we_ok
);

    localparam int SIDES = 2;   // index 0 software, 1 hardware

    logic req_q, ack_q, handover, viol_q;
    logic req_wr_en, req_wr_val;
    logic [SIDES-1:0] side_we, side_sel, side_ok, side_refused;
    logic refuse_any;

    dbuf_hs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_wr_en  (req_wr_en),
        .req_wr_val (req_wr_val),
        .hw_done    (hw_done),
        .req_q      (req_q),
        .ack_q      (ack_q),
        .handover   (handover)
    );

    always_comb begin
        side_we  = {hw_mem_we,  sw_mem_we};
        side_sel = {hw_mem_sel, sw_mem_sel};
    end

    // side s owns region phase ^ s
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam logic SIDE_INV = (s != 0);
        dbuf_wr_gate u_gate (
            .mem_we       (side_we[s]),
            .mem_sel      (side_sel[s]),
            .owned_region (ack_q ^ SIDE_INV),
            .freeze       (handover),
            .we_ok        (side_ok[s]),
            .refused      (side_refused[s])
        );
    end

    always_comb begin
        refuse_any   = |side_refused;
        sw_mem_we_ok = side_ok[0];
        hw_mem_we_ok = side_ok[1];
        sw_region    = ack_q;
        hw_region    = ~ack_q;
    end

    dbuf_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .req_q      (req_q),
        .ack_q      (ack_q),
        .refuse_any (refuse_any),
        .reg_rdata  (reg_rdata),
        .req_wr_en  (req_wr_en),
        .req_wr_val (req_wr_val),
        .viol_q     (viol_q)
    );

endmodule

// File: rtl/dbuf_own_ctrl_chk.sv
module dbuf_own_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic hw_done,
    input logic sw_mem_we,
    input logic sw_mem_sel,
    input logic hw_mem_we,
    input logic hw_mem_sel,
    input logic sw_mem_we_ok,
    input logic hw_mem_we_ok,
    input logic sw_region,
    input logic req_q,
    input logic ack_q,
    input logic viol_q,
    input logic handover
);

    p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q == ack_q && !handover) |=> $stable(ack_q));

    p_done_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!handover && req_q != ack_q && hw_done) |=> handover);

    p_handover_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        handover |=> (ack_q != $past(ack_q)));

    p_sw_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mem_we_ok |-> (sw_mem_we && sw_mem_sel == sw_region && !handover));

    p_hw_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mem_we_ok |-> (hw_mem_we && hw_mem_sel != sw_region && !handover));

    p_refuse_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_mem_we && !sw_mem_we_ok) || (hw_mem_we && !hw_mem_we_ok)) |=> viol_q);

    p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> viol_q);

    p_req_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        handover |=> $stable(req_q));

endmodule

bind dbuf_own_ctrl dbuf_own_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_done      (hw_done),
    .sw_mem_we    (sw_mem_we),
    .sw_mem_sel   (sw_mem_sel),
    .hw_mem_we    (hw_mem_we),
    .hw_mem_sel   (hw_mem_sel),
    .sw_mem_we_ok (sw_mem_we_ok),
    .hw_mem_we_ok (hw_mem_we_ok),
    .sw_region    (sw_region),
    .req_q        (req_q),
    .ack_q        (ack_q),
    .viol_q       (viol_q),
    .handover     (handover)
);

// File: tb/tb_dbuf_own_ctrl.sv
`timescale 1ns/1ps
module tb_dbuf_own_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_done = 1'b0;
    logic        sw_mem_we = 1'b0, sw_mem_sel = 1'b0;
    logic        hw_mem_we = 1'b0, hw_mem_sel = 1'b0;
    logic        sw_region, hw_region, sw_mem_we_ok, hw_mem_we_ok;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    bit m_req, m_ack, m_swap, m_viol;

    always #2.5 clk = ~clk;

    dbuf_own_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_done(hw_done),
        .sw_mem_we(sw_mem_we), .sw_mem_sel(sw_mem_sel),
        .hw_mem_we(hw_mem_we), .hw_mem_sel(hw_mem_sel),
        .sw_region(sw_region), .hw_region(hw_region),
        .sw_mem_we_ok(sw_mem_we_ok), .hw_mem_we_ok(hw_mem_we_ok)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req = 0; m_ack = 0; m_swap = 0; m_viol = 0;
        end else begin
            bit nreq;
            nreq = m_req;
            if ((sw_mem_we && (m_swap || sw_mem_sel != m_ack)) ||
                (hw_mem_we && (m_swap || hw_mem_sel == m_ack)))
                m_viol = 1;
            if (reg_we && reg_addr == 2'd0 && !m_swap) nreq = reg_wdata[0];
            if (m_swap) begin
                m_ack = ~m_ack; m_swap = 0;
            end else if (m_req != m_ack && hw_done) begin
                m_swap = 1;
            end
            m_req = nreq;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            2'd0: r[0] = m_req;
            2'd1: r[0] = m_ack;
            2'd2: r = {29'd0, m_req ^ m_ack, m_ack, m_viol};
            default: r = '0;
        endcase
        return r;
    endfunction

    // one cycle: drive after falling edge, compare against the model
    task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                       input logic hd, input logic swe, input logic ssel,
                       input logic hwe, input logic hsel);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; hw_done = hd;
        sw_mem_we = swe; sw_mem_sel = ssel; hw_mem_we = hwe; hw_mem_sel = hsel;
        #1;
        chk("R7 sw_region", {31'd0, sw_region}, {31'd0, m_ack});
        chk("R7 hw_region", {31'd0, hw_region}, {31'd0, ~m_ack});
        chk("R8 sw_mem_we_ok", {31'd0, sw_mem_we_ok},
            {31'd0, swe && !m_swap && ssel == m_ack});
        chk("R9 hw_mem_we_ok", {31'd0, hw_mem_we_ok},
            {31'd0, hwe && !m_swap && hsel != m_ack});
        chk("R2 reg_rdata", reg_rdata, exp_rd(a));
    endtask

    task automatic rd(input logic [1:0] a);
        cyc(0, a, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2); chk("R1 status", reg_rdata, 32'h0);
        rd(0); chk("R1 req", reg_rdata, 32'h0);
        rd(1); chk("R1 ack", reg_rdata, 32'h0);
        chk("R1 regions", {30'd0, sw_region, hw_region}, 32'h1);
        rd(3); chk("R2 unused address", reg_rdata, 32'h0);
        // R6 hw_done with nothing pending
        cyc(0, 1, 0, 1, 0, 0, 0, 0);
        rd(1); chk("R6 ack after idle done", reg_rdata, 32'h0);
        // R8 / R9 owned writes pass
        cyc(0, 2, 0, 0, 1, 0, 1, 1);
        chk("R8 own write passes", {31'd0, sw_mem_we_ok}, 32'h1);
        chk("R9 own write passes", {31'd0, hw_mem_we_ok}, 32'h1);
        rd(2); chk("R10 no violation yet", reg_rdata, 32'h0);
        // R10 refused software write
        cyc(0, 2, 0, 0, 1, 1, 0, 0);
        chk("R8 foreign write refused", {31'd0, sw_mem_we_ok}, 32'h0);
        rd(2); chk("R10 violation set", reg_rdata, 32'h1);
        // R3 ack/status not writable
        cyc(1, 1, 32'h1, 0, 0, 0, 0, 0);
        cyc(1, 2, 32'h0, 0, 0, 0, 0, 0);
        rd(1); chk("R3 ack unwritable", reg_rdata, 32'h0);
        rd(2); chk("R10 sticky after write", reg_rdata, 32'h1);
        // R4 request pending
        cyc(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        rd(0); chk("R3 req loaded", reg_rdata, 32'h1);
        rd(2); chk("R4 pending", reg_rdata, 32'h5);
        repeat (4) rd(1);
        chk("R4 ack held", reg_rdata, 32'h0);
        // R5 hand-over, R11 write during hand-over
        cyc(0, 1, 0, 1, 0, 0, 0, 0);
        cyc(1, 0, 32'h0, 0, 1, 0, 1, 1);
        chk("R8 blocked in hand-over", {31'd0, sw_mem_we_ok}, 32'h0);
        chk("R9 blocked in hand-over", {31'd0, hw_mem_we_ok}, 32'h0);
        rd(1); chk("R5 ack toggled", reg_rdata, 32'h1);
        rd(0); chk("R11 req write ignored", reg_rdata, 32'h1);
        rd(2); chk("R5 status after swap", reg_rdata, 32'h3);
        chk("R7 regions swapped", {30'd0, sw_region, hw_region}, 32'h2);
        // R9 hardware now owns region 0
        cyc(0, 2, 0, 0, 1, 1, 1, 0);
        chk("R9 hw writes region 0", {31'd0, hw_mem_we_ok}, 32'h1);
        // R12 withdrawal
        cyc(1, 0, 32'h0, 0, 0, 0, 0, 0);
        cyc(1, 0, 32'h1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0, 0, 0);
        rd(1); rd(1); chk("R12 withdrawn swap", reg_rdata, 32'h1);
        // second swap, done immediately after request
        cyc(1, 0, 32'h0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0, 0, 0);
        rd(1); chk("R5 during hand-over", reg_rdata, 32'h1);
        rd(1); chk("R5 ack back to 0", reg_rdata, 32'h0);
        // R10 reset clears violation
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2); chk("R10 cleared by reset", reg_rdata, 32'h0);
        repeat (3) rd(0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule